// File: doc/BRIEF.md
# Loopback Connector Continuity Tester

This block runs a production self-test on the wiring of a board connector. An external cable connects every differential output pair of one connector to the matching input of a second connector. After a start request, the block works through the pairs in ascending order. For the pair under test it sends a fixed burst of clock pulses on that one output and holds every other output low. It then waits for an idle gap, which absorbs the cable delay. During the burst and the gap it counts two things: rising edges on the input that should receive the burst, and rising edges on every other input.

For each pair the block writes one result record into a sink memory through a simple write port. A pair passes only when its own input saw exactly the burst length and no other input saw any activity. A register-style status readout gives the overall go/no-go result. It holds a sticky fail bit and the index of the first failing pair, and both stay valid until the next start. The returned inputs are asynchronous to the tester clock, so each one passes through a synchronizer before its edges are detected.

Top module: `lbk_cont_tester`

## Requirements
- R1: While reset is asserted and directly after it, busy_o, done_o, rec_we_o, fail_o and first_fail_vld_o are low and tx_o is all zero.
- R2: During a run, at most one bit of tx_o is high at any time. While pair p is under test, tx_o[p] makes exactly BURST_LEN pulses, each high for one cycle and low for one cycle, and every other bit of tx_o stays 0. When no run is active, tx_o is 0.
- R3: Pairs are tested in ascending order, from 0 to NUM_PAIRS-1. Each pair produces exactly one record, and rec_addr_o of that record equals the pair index.
- R4: Let the effective gap be G = max(gap_cfg_i, 8), with gap_cfg_i sampled when start is accepted. Let P = 2*BURST_LEN + G + 1. The record for pair i is presented P*(i+1) cycles after the clock edge that accepts start, and rec_we_o is high for one cycle per record.
- R5: The match count in a record is the number of rising edges seen on rx_i[p] during the burst and gap of pair p. The stray count is the total number of rising edges on all other rx_i bits in the same window. Both counts saturate at all ones (CNT_W bits).
- R6: The pass bit is 1 exactly when the match count equals BURST_LEN and the stray count is 0.
- R7: rec_data_o is laid out, from MSB to LSB, as: pair index (IDX_W bits), match count (CNT_W bits), stray count (CNT_W bits), pass bit (bit 0).
- R8: fail_o is set by the first record whose pass bit is 0 and then stays set until the next accepted start. When it is set, first_fail_idx_o and first_fail_vld_o record that pair's index. A run with no failing pair leaves fail_o and first_fail_vld_o at 0.
- R9: done_o is high for exactly one cycle, namely the cycle after the last record. busy_o is already low in that cycle.
- R10: busy_o rises in the cycle after start_i is accepted while idle. A start_i pulse during a run is ignored, and the record schedule of that run does not change.
- R11: A gap_cfg_i value below 8 gives the same timing as a value of 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tester clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request; accepted only when idle |
| gap_cfg_i | input | GAP_W | Idle gap after each burst, in cycles (minimum 8) |
| tx_o | output | NUM_PAIRS | Test drive, one bit per output pair |
| rx_i | input | NUM_PAIRS | Looped-back inputs, asynchronous |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| fail_o | output | 1 | Sticky overall fail (no-go) |
| first_fail_vld_o | output | 1 | first_fail_idx_o holds a failing pair |
| first_fail_idx_o | output | IDX_W | Index of the first failing pair |
| rec_we_o | output | 1 | Sink memory write strobe |
| rec_addr_o | output | IDX_W | Sink memory address (pair index) |
| rec_data_o | output | IDX_W+2*CNT_W+1 | Result record |

## Verification
Every result has a fixed due cycle, counted from the edge that accepts start:
- The record for pair i is due P*(i+1) cycles after that edge.
- done_o follows the last record one cycle later.
- busy_o is high at the first sample after acceptance.
- The status outputs reflect a failing record one cycle after it.

The bench keeps a cycle counter, timestamps every record at the falling edge, and compares each timestamp with the cycle computed from the requirements. Record contents are compared after the run against counts derived from the bench's own fault model: opens, shorts and multi-lane shorts that drive the stray count into saturation.

// File: rtl/lbk_pkg.sv
package lbk_pkg;

   // Minimum idle gap after each burst, in cycles.
   localparam int MIN_GAP = 8;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_BURST = 2'd1,
      ST_GAP   = 2'd2,
      ST_EVAL  = 2'd3
   } lbk_state_e;

endpackage

// File: rtl/lbk_rx_edge.sv
// Brings the looped-back inputs into the clock domain and detects rising edges.
module lbk_rx_edge #(
   parameter int LANES  = 64,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] din_i,
   output logic [LANES-1:0] rise_o
);

   logic [STAGES-1:0][LANES-1:0] chain_q;
   logic [LANES-1:0]             last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], din_i};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign rise_o = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/lbk_counters.sv
// Match counter for the lane under test and stray counter for all other lanes.
module lbk_counters #(
   parameter int LANES = 64,
   parameter int IDX_W = 6,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             en_i,
   input  logic [LANES-1:0] rise_i,
   input  logic [IDX_W-1:0] idx_i,
   output logic [CNT_W-1:0] match_o,
   output logic [CNT_W-1:0] stray_o
);

   localparam int ONES_W = $clog2(LANES + 1);
   localparam int SUM_W  = ((CNT_W > ONES_W) ? CNT_W : ONES_W) + 1;
   localparam logic [SUM_W-1:0] CNT_MAX = SUM_W'({CNT_W{1'b1}});

   logic [LANES-1:0]  own_rise;
   logic [LANES-1:0]  other_rise;
   logic [ONES_W-1:0] other_ones;
   logic [SUM_W-1:0]  stray_sum;
   logic [CNT_W-1:0]  match_q, stray_q;
   logic              hit_own;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign own_rise[l]   = rise_i[l] &  (idx_i == IDX_W'(l));
      assign other_rise[l] = rise_i[l] & ~(idx_i == IDX_W'(l));
   end

   assign hit_own    = |own_rise;
   assign other_ones = ONES_W'($countones(other_rise));
   assign stray_sum  = SUM_W'(stray_q) + SUM_W'(other_ones);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_q <= '0;
         stray_q <= '0;
      end else if (clr_i) begin
         match_q <= '0;
         stray_q <= '0;
      end else if (en_i) begin
         if (hit_own && (match_q != {CNT_W{1'b1}}))
            match_q <= match_q + 1'b1;
         stray_q <= (stray_sum > CNT_MAX) ? {CNT_W{1'b1}} : stray_sum[CNT_W-1:0];
      end
   end

   assign match_o = match_q;
   assign stray_o = stray_q;

endmodule

// File: rtl/lbk_seq.sv
// Run sequencer: burst on one pair, idle gap, evaluate, next pair.
module lbk_seq
   import lbk_pkg::*;
#(
   parameter int LANES     = 64,
   parameter int BURST_LEN = 64,
   parameter int GAP_W     = 8,
   parameter int IDX_W     = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [GAP_W-1:0] gap_cfg_i,
   output logic [LANES-1:0] tx_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             cnt_clr_o,
   output logic             cnt_en_o,
   output logic             eval_o,
   output logic             busy_o,
   output logic             done_o
);

   localparam int BC_W = $clog2(2 * BURST_LEN);
   localparam logic [BC_W-1:0]  BC_LAST  = BC_W'(2 * BURST_LEN - 1);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(LANES - 1);
   localparam logic [GAP_W-1:0] GAP_MIN  = GAP_W'(MIN_GAP);

   lbk_state_e       state_q;
   logic [IDX_W-1:0] idx_q;
   logic [BC_W-1:0]  bcnt_q;
   logic [GAP_W-1:0] gcnt_q, glen_q;
   logic             done_q;
   logic             accept;
   logic             burst_hi;
   logic [GAP_W-1:0] gap_eff;

   assign accept  = (state_q == ST_IDLE) && start_i;
   assign gap_eff = (gap_cfg_i < GAP_MIN) ? GAP_MIN : gap_cfg_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         bcnt_q  <= '0;
         gcnt_q  <= '0;
         glen_q  <= GAP_MIN;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q <= ST_BURST;
                  idx_q   <= '0;
                  bcnt_q  <= '0;
                  glen_q  <= gap_eff;
               end
            end
            ST_BURST: begin
               if (bcnt_q == BC_LAST) begin
                  state_q <= ST_GAP;
                  gcnt_q  <= '0;
               end else begin
                  bcnt_q <= bcnt_q + 1'b1;
               end
            end
            ST_GAP: begin
               if (gcnt_q == glen_q - 1'b1)
                  state_q <= ST_EVAL;
               else
                  gcnt_q <= gcnt_q + 1'b1;
            end
            default: begin
               if (idx_q == IDX_LAST) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  idx_q   <= idx_q + 1'b1;
                  bcnt_q  <= '0;
                  state_q <= ST_BURST;
               end
            end
         endcase
      end
   end

   assign burst_hi = (state_q == ST_BURST) && !bcnt_q[0];

   for (genvar l = 0; l < LANES; l++) begin : g_drive
      assign tx_o[l] = burst_hi && (idx_q == IDX_W'(l));
   end

   assign idx_o     = idx_q;
   assign cnt_clr_o = accept || (state_q == ST_EVAL);
   assign cnt_en_o  = (state_q == ST_BURST) || (state_q == ST_GAP);
   assign eval_o    = (state_q == ST_EVAL);
   assign busy_o    = (state_q != ST_IDLE);
   assign done_o    = done_q;

endmodule

// File: rtl/lbk_cont_tester.sv
module lbk_cont_tester
   import lbk_pkg::*;
#(
   parameter int NUM_PAIRS   = 64,
   parameter int BURST_LEN   = 64,
   parameter int GAP_W       = 8,
   parameter int SYNC_STAGES = 2,
   localparam int IDX_W = $clog2(NUM_PAIRS),
   localparam int CNT_W = $clog2(BURST_LEN + 1) + 1,
   localparam int REC_W = IDX_W + 2 * CNT_W + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [GAP_W-1:0]     gap_cfg_i,
   output logic [NUM_PAIRS-1:0] tx_o,
   input  logic [NUM_PAIRS-1:0] rx_i,
   output logic                 busy_o,
   output logic                 done_o,
   output logic                 fail_o,
   output logic                 first_fail_vld_o,
   output logic [IDX_W-1:0]     first_fail_idx_o,
   output logic                 rec_we_o,
   output logic [IDX_W-1:0]     rec_addr_o,
   output logic [REC_W-1:0]     rec_data_o
);

   // Elaboration-time parameter checks.
   if (NUM_PAIRS < 2) begin : g_bad_pairs
      $error("NUM_PAIRS must be at least 2");
   end
   if (BURST_LEN < 1) begin : g_bad_burst
      $error("BURST_LEN must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (((1 << GAP_W) - 1) < MIN_GAP) begin : g_bad_gap
      $error("GAP_W too narrow for the minimum gap");
   end

   logic [NUM_PAIRS-1:0] rise;
   logic [IDX_W-1:0]     idx;
   logic                 cnt_clr, cnt_en, eval;
   logic [CNT_W-1:0]     match_cnt, stray_cnt;
   logic                 pair_ok;
   logic                 fail_q, vld_q;
   logic [IDX_W-1:0]     first_q;

   lbk_seq #(
      .LANES(NUM_PAIRS), .BURST_LEN(BURST_LEN), .GAP_W(GAP_W), .IDX_W(IDX_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .gap_cfg_i(gap_cfg_i),
      .tx_o(tx_o), .idx_o(idx), .cnt_clr_o(cnt_clr), .cnt_en_o(cnt_en),
      .eval_o(eval), .busy_o(busy_o), .done_o(done_o)
   );

   lbk_rx_edge #(
      .LANES(NUM_PAIRS), .STAGES(SYNC_STAGES)
   ) u_rx (
      .clk(clk), .rst_n(rst_n), .din_i(rx_i), .rise_o(rise)
   );

   lbk_counters #(
      .LANES(NUM_PAIRS), .IDX_W(IDX_W), .CNT_W(CNT_W)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .en_i(cnt_en),
      .rise_i(rise), .idx_i(idx), .match_o(match_cnt), .stray_o(stray_cnt)
   );

   assign pair_ok = (match_cnt == CNT_W'(BURST_LEN)) && (stray_cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fail_q  <= 1'b0;
         vld_q   <= 1'b0;
         first_q <= '0;
      end else if (start_i && !busy_o) begin
         fail_q  <= 1'b0;
         vld_q   <= 1'b0;
         first_q <= '0;
      end else if (eval && !pair_ok) begin
         fail_q <= 1'b1;
         if (!vld_q) begin
            vld_q   <= 1'b1;
            first_q <= idx;
         end
      end
   end

   assign fail_o           = fail_q;
   assign first_fail_vld_o = vld_q;
   assign first_fail_idx_o = first_q;
   assign rec_we_o         = eval;
   assign rec_addr_o       = idx;
   assign rec_data_o       = {idx, match_cnt, stray_cnt, pair_ok};

endmodule

// File: rtl/lbk_checker.sv
module lbk_checker #(
   parameter int LANES     = 64,
   parameter int BURST_LEN = 64,
   parameter int IDX_W     = 6,
   parameter int CNT_W     = 8,
   parameter int REC_W     = IDX_W + 2 * CNT_W + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [LANES-1:0] tx_o,
   input logic             busy_o,
   input logic             done_o,
   input logic             fail_o,
   input logic             rec_we_o,
   input logic [REC_W-1:0] rec_data_o
);

   logic [CNT_W-1:0] f_match, f_stray;
   logic             f_pass;
   assign f_match = rec_data_o[2*CNT_W:CNT_W+1];
   assign f_stray = rec_data_o[CNT_W:1];
   assign f_pass  = rec_data_o[0];

   assert_tx_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tx_o));

   assert_tx_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (tx_o == '0));

   assert_rec_in_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rec_we_o |-> busy_o);

   assert_rec_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rec_we_o |=> !rec_we_o);

   assert_pass_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rec_we_o |-> (f_pass == ((f_match == CNT_W'(BURST_LEN)) && (f_stray == '0))));

   assert_fail_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_we_o && !f_pass) |=> fail_o);

   assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o) && $past(fail_o)) |-> fail_o);

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(rec_we_o)));

   assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));

endmodule

bind lbk_cont_tester lbk_checker #(
   .LANES(NUM_PAIRS), .BURST_LEN(BURST_LEN), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .tx_o(tx_o), .busy_o(busy_o),
   .done_o(done_o), .fail_o(fail_o), .rec_we_o(rec_we_o), .rec_data_o(rec_data_o)
);

// File: tb/lbk_cont_tester_bench.sv
module lbk_cont_tester_bench;
   localparam int N     = 16;
   localparam int BL    = 64;
   localparam int GW    = 8;
   localparam int IDX_W = $clog2(N);
   localparam int CNT_W = $clog2(BL + 1) + 1;
   localparam int REC_W = IDX_W + 2 * CNT_W + 1;
   localparam int CMAX  = (1 << CNT_W) - 1;

   logic clk = 0, rst_n = 0, start_i = 0;
   logic [GW-1:0] gap_cfg_i = 0;
   logic [N-1:0] tx_o, rx_i;
   logic busy_o, done_o, fail_o, first_fail_vld_o, rec_we_o;
   logic [IDX_W-1:0] first_fail_idx_o, rec_addr_o;
   logic [REC_W-1:0] rec_data_o;

   always #5 clk = ~clk;

   lbk_cont_tester #(.NUM_PAIRS(N), .BURST_LEN(BL), .GAP_W(GW)) u_lbk_cont_tester (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .gap_cfg_i(gap_cfg_i),
      .tx_o(tx_o), .rx_i(rx_i), .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
      .first_fail_vld_o(first_fail_vld_o), .first_fail_idx_o(first_fail_idx_o),
      .rec_we_o(rec_we_o), .rec_addr_o(rec_addr_o), .rec_data_o(rec_data_o)
   );

   // Cable fault model: open lanes, and xm[j][k] means tx[k] also reaches lane j.
   logic         open_m [N];
   logic [N-1:0] xm     [N];
   always_comb begin
      for (int j = 0; j < N; j++)
         rx_i[j] = (tx_o[j] & ~open_m[j]) | (|(tx_o & xm[j]));
   end

   int total = 0, bad = 0, cyc = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Monitor state
   int nrec, ndone, multihot, busy_at_done;
   int rec_a [N];
   int rec_d [N];
   int rec_c [N];
   int tx_rises [N];
   logic [N-1:0] tx_prev;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (rec_we_o && nrec < N) begin
            rec_a[nrec] = rec_addr_o;
            rec_d[nrec] = int'(rec_data_o);
            rec_c[nrec] = cyc;
         end
         if (rec_we_o) nrec++;
         if (done_o) begin
            ndone++;
            if (busy_o) busy_at_done++;
         end
         if ($countones(tx_o) > 1) multihot++;
         for (int l = 0; l < N; l++)
            if (tx_o[l] && !tx_prev[l]) tx_rises[l]++;
         tx_prev = tx_o;
      end
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         chk(0, "watchdog", cyc, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   function automatic int exp_match(int k);
      return open_m[k] ? 0 : BL;
   endfunction

   function automatic int exp_stray(int k);
      int s = 0;
      for (int j = 0; j < N; j++)
         if (j != k && xm[j][k]) s += BL;
      return (s > CMAX) ? CMAX : s;
   endfunction

   task automatic clear_faults();
      for (int j = 0; j < N; j++) begin
         open_m[j] = 0;
         xm[j] = '0;
      end
   endtask

   task automatic run(input int gap, input bit poke_start);
      int start_cyc, geff, per, exp_first, any_fail;
      nrec = 0; ndone = 0; multihot = 0; busy_at_done = 0;
      for (int l = 0; l < N; l++) tx_rises[l] = 0;
      @(negedge clk);
      gap_cfg_i = GW'(gap);
      start_i = 1;
      start_cyc = cyc;
      @(negedge clk);
      start_i = 0;
      chk(busy_o === 1'b1, "R10 busy after start", busy_o, 1);
      if (poke_start) begin
         repeat (200) @(negedge clk);
         start_i = 1;
         @(negedge clk);
         start_i = 0;
      end
      while (!done_o) @(negedge clk);
      repeat (2) @(negedge clk);
      geff = (gap < 8) ? 8 : gap;
      per = 2 * BL + geff + 1;
      chk(nrec == N, "R3 record count", nrec, N);
      exp_first = -1;
      any_fail = 0;
      for (int i = 0; i < N && i < nrec; i++) begin
         int ei, em, es, ep;
         em = exp_match(i);
         es = exp_stray(i);
         ep = (em == BL && es == 0) ? 1 : 0;
         if (!ep) begin
            any_fail = 1;
            if (exp_first < 0) exp_first = i;
         end
         chk(rec_a[i] == i, "R3 record address", rec_a[i], i);
         chk(rec_c[i] == start_cyc + (i + 1) * per, "R4 R11 record cycle", rec_c[i],
             start_cyc + (i + 1) * per);
         ei = (rec_d[i] >> (2 * CNT_W + 1)) & ((1 << IDX_W) - 1);
         chk(ei == i, "R7 index field", ei, i);
         chk(((rec_d[i] >> (CNT_W + 1)) & CMAX) == em, "R5 match count",
             (rec_d[i] >> (CNT_W + 1)) & CMAX, em);
         chk(((rec_d[i] >> 1) & CMAX) == es, "R5 stray count", (rec_d[i] >> 1) & CMAX, es);
         chk((rec_d[i] & 1) == ep, "R6 pass bit", rec_d[i] & 1, ep);
      end
      for (int l = 0; l < N; l++)
         chk(tx_rises[l] == BL, "R2 pulses per pair", tx_rises[l], BL);
      chk(multihot == 0, "R2 single active output", multihot, 0);
      chk(tx_o == '0, "R2 outputs quiet after run", int'(tx_o), 0);
      chk(ndone == 1, "R9 one done pulse", ndone, 1);
      chk(busy_at_done == 0, "R9 busy low at done", busy_at_done, 0);
      chk(busy_o == 0, "R9 busy cleared", busy_o, 0);
      chk(fail_o == any_fail, "R8 overall fail", fail_o, any_fail);
      chk(first_fail_vld_o == any_fail, "R8 first fail valid", first_fail_vld_o, any_fail);
      if (any_fail)
         chk(first_fail_idx_o == exp_first, "R8 first fail index", first_fail_idx_o, exp_first);
   endtask

   initial begin
      int a, b, c;
      void'($urandom(32'd4242));
      clear_faults();
      tx_prev = '0;
      repeat (3) @(negedge clk);
      chk(busy_o == 0 && done_o == 0 && rec_we_o == 0, "R1 control low in reset", busy_o, 0);
      chk(tx_o == '0, "R1 tx idle in reset", int'(tx_o), 0);
      rst_n = 1;
      @(negedge clk);
      chk(fail_o == 0 && first_fail_vld_o == 0, "R1 status clear", fail_o, 0);

      // Clean cable, gap below minimum (R11), with a start pulse mid-run (R10).
      run(3, 1'b1);
      // Clean cable, exactly minimum gap.
      run(8, 1'b0);
      // Directed: open on last pair, short from pair 2 onto lane 9.
      open_m[N-1] = 1;
      xm[9][2] = 1;
      run(12, 1'b0);
      // Directed: stray saturation, pair 5 shorted onto four lanes (R5).
      clear_faults();
      for (int j = 0; j < 4; j++) xm[8 + j][5] = 1;
      run(9, 1'b0);
      // Random faults.
      for (int r = 0; r < 4; r++) begin
         clear_faults();
         a = $urandom % N;
         b = $urandom % N;
         c = (b + 1 + ($urandom % (N - 1))) % N;
         open_m[a] = 1;
         xm[c][b] = 1;
         run(8 + ($urandom % 20), 1'b0);
      end
      // Clean run after failures: status must clear on start (R8).
      clear_faults();
      run(10, 1'b0);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule